// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small processor with one accumulator. It executes a stored program one instruction at a time. Each instruction is split into single register transfers, one per clock cycle. The transfers pass through a program counter, a memory address register (MAR), a memory data register (MDR), an instruction register (IR) and a registered decode of the opcode. Every memory access, for instructions and for operands, goes through MAR and MDR over one shared memory port. The memory is built into the block.

An instruction word is 16 bits. The opcode sits in bits [15:12] and the operand address in bits [11:0]. The opcodes are 0 to load the accumulator, 1 to add to it, 2 to store it, and F to halt. Every other opcode value does nothing. The built-in memory has 2^MEM_AW words and uses only the low MEM_AW bits of an address.

The `run` input enables the core. While `run` is low, the core holds its state and a host port owns the memory port. The host uses it to place a program and its data in memory and to read results back.

Top module: `acc_core`

## Requirements
- R1: After reset is released, `pc` is 0, `acc` is 0 and `halted` is 0. The first instruction is fetched from address 0.
- R2: Fetch takes three cycles: MAR takes PC and PC increments by one in the same cycle, then MDR takes the memory word, then IR takes MDR. A fourth cycle loads MAR from the address field and registers the opcode decode. When `pc` changes, it changes by exactly +1.
- R3: LOAD (opcode 0) takes six cycles. The fifth cycle reads memory at MAR into MDR and the sixth copies MDR into the accumulator. With run held high from the first fetch cycle, `acc` takes the new value at the sixth rising edge.
- R4: ADD (opcode 1) takes six cycles and sets the accumulator to the accumulator plus the operand, modulo 2^16. No flags are produced.
- R5: STORE (opcode 2) takes six cycles. It copies the accumulator into MDR and then writes MDR to memory at MAR. The accumulator is unchanged.
- R6: HALT (opcode F) is reached four cycles after its fetch begins. `halted` then stays 1, and `pc` and `acc` hold, until reset. `pc` holds the address after the halt word.
- R7: Opcodes 3 to E take four cycles, change neither the accumulator nor memory, and are followed by a fetch of the next word.
- R8: While `run` is 0, all core registers hold. Memory is read at `host_addr` on `host_rdata` and written from `host_wdata` when `host_we` is 1. While `run` is 1, the core owns the memory port and `host_we` is ignored.
- R9: Operand address bits at and above MEM_AW are ignored. With MEM_AW = 8, address 0x940 refers to the same word as 0x040.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run | input | 1 | Core enable; when low the host owns the memory port |
| host_we | input | 1 | Host write strobe, honoured only while run is low |
| host_addr | input | MEM_AW | Host memory word address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Memory word at the port address |
| pc | output | ADDR_W | Program counter |
| acc | output | DATA_W | Accumulator |
| halted | output | 1 | High once a HALT instruction has been decoded |

## Verification
A load, add, store and halt program runs over a table of operand pairs: zeros, small values, carries out of bit 15, sign-bit pairs, and all-ones pairs that produce 0xFFFE. These pairs separate a correct modulo sum from a truncation or carry error, and they show that the stored result matches the accumulator. A single-step run counts edges against the fetch and execute cycles, so an extra or missing state shows up as a timing miscompare. Further programs mix undefined opcodes and address fields with high bits set, which separates true no-ops and address folding from stray writes. A pause in the middle of an instruction, with a host write during the pause, shows that the core freezes and that the single port is shared.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

  localparam logic [3:0] OPC_LOAD  = 4'h0;
  localparam logic [3:0] OPC_ADD   = 4'h1;
  localparam logic [3:0] OPC_STORE = 4'h2;
  localparam logic [3:0] OPC_HALT  = 4'hF;

  typedef enum logic [3:0] {
    ST_FADDR,   // MAR <- PC, PC <- PC + 1
    ST_FREAD,   // MDR <- M[MAR]
    ST_FIR,     // IR  <- MDR
    ST_DEC,     // MAR <- IR.addr, decode <- IR.op
    ST_DREAD,   // MDR <- M[MAR]
    ST_EXEC,    // A <- MDR  or  A <- A + MDR
    ST_SDATA,   // MDR <- A
    ST_SWRITE,  // M[MAR] <- MDR
    ST_HALT
  } state_e;

  typedef enum logic [2:0] {
    OPK_NONE,
    OPK_LOAD,
    OPK_ADD,
    OPK_STORE,
    OPK_HALT
  } opkind_e;

  typedef struct packed {
    logic mar_from_pc;
    logic mdr_from_mem;
    logic ir_from_mdr;
    logic mar_from_ir;
    logic acc_from_mdr;
    logic acc_add_mdr;
    logic mdr_from_acc;
  } xfer_t;

  function automatic opkind_e decode_op(input logic [3:0] op);
    case (op)
      OPC_LOAD:  decode_op = OPK_LOAD;
      OPC_ADD:   decode_op = OPK_ADD;
      OPC_STORE: decode_op = OPK_STORE;
      OPC_HALT:  decode_op = OPK_HALT;
      default:   decode_op = OPK_NONE;
    endcase
  endfunction

endpackage

// File: rtl/acc_core_mem.sv
module acc_core_mem #(
  parameter int DATA_W = 16,
  parameter int AW     = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      words[addr] <= wdata;
    end
  end

  // read value is captured by MDR at the next edge
  assign rdata = words[addr];

endmodule

// File: rtl/acc_core_ctrl.sv
module acc_core_ctrl
  import acc_core_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [OP_W-1:0] ir_op,
  output xfer_t           xfer,
  output logic            mem_we,
  output logic            halted
);
  state_e  state_q, state_d;
  opkind_e kind_q,  kind_d;

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    xfer    = '0;
    mem_we  = 1'b0;
    if (en) begin
      case (state_q)
        ST_FADDR: begin
          xfer.mar_from_pc = 1'b1;
          state_d = ST_FREAD;
        end
        ST_FREAD: begin
          xfer.mdr_from_mem = 1'b1;
          state_d = ST_FIR;
        end
        ST_FIR: begin
          xfer.ir_from_mdr = 1'b1;
          state_d = ST_DEC;
        end
        ST_DEC: begin
          xfer.mar_from_ir = 1'b1;
          kind_d = decode_op(4'(ir_op));
          case (kind_d)
            OPK_LOAD, OPK_ADD: state_d = ST_DREAD;
            OPK_STORE:         state_d = ST_SDATA;
            OPK_HALT:          state_d = ST_HALT;
            default:           state_d = ST_FADDR;
          endcase
        end
        ST_DREAD: begin
          xfer.mdr_from_mem = 1'b1;
          state_d = ST_EXEC;
        end
        ST_EXEC: begin
          if (kind_q == OPK_LOAD) xfer.acc_from_mdr = 1'b1;
          else                    xfer.acc_add_mdr  = 1'b1;
          state_d = ST_FADDR;
        end
        ST_SDATA: begin
          xfer.mdr_from_acc = 1'b1;
          state_d = ST_SWRITE;
        end
        ST_SWRITE: begin
          mem_we  = 1'b1;
          state_d = ST_FADDR;
        end
        ST_HALT:  state_d = ST_HALT;
        default:  state_d = ST_FADDR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FADDR;
      kind_q  <= OPK_NONE;
    end else if (en) begin
      state_q <= state_d;
      kind_q  <= kind_d;
    end
  end

  assign halted = (state_q == ST_HALT);

  // R3
  exec_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EXEC) |-> (kind_q == OPK_LOAD || kind_q == OPK_ADD));

  // R7
  write_only_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (kind_q == OPK_STORE));

  // R2
  one_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xfer, mem_we}));

endmodule

// File: rtl/acc_core_dp.sv
module acc_core_dp
  import acc_core_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OP_W   = 4,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  xfer_t             xfer,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mdr,
  output logic [OP_W-1:0]   ir_op,
  output logic [DATA_W-1:0] acc
);
  localparam int OP_LSB = DATA_W - OP_W;

  logic [ADDR_W-1:0] pc_q,  pc_d;
  logic [ADDR_W-1:0] mar_q, mar_d;
  logic [DATA_W-1:0] mdr_q, mdr_d;
  logic [DATA_W-1:0] ir_q,  ir_d;
  logic [DATA_W-1:0] acc_q, acc_d;

  always_comb begin
    pc_d  = pc_q;
    mar_d = mar_q;
    mdr_d = mdr_q;
    ir_d  = ir_q;
    acc_d = acc_q;
    if (xfer.mar_from_pc) begin
      mar_d = pc_q;
      pc_d  = pc_q + ADDR_W'(1);
    end
    if (xfer.mar_from_ir)  mar_d = ir_q[ADDR_W-1:0];
    if (xfer.mdr_from_mem) mdr_d = mem_rdata;
    if (xfer.mdr_from_acc) mdr_d = acc_q;
    if (xfer.ir_from_mdr)  ir_d  = mdr_q;
    if (xfer.acc_from_mdr) acc_d = mdr_q;
    if (xfer.acc_add_mdr)  acc_d = acc_q + mdr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
      acc_q <= '0;
    end else if (en) begin
      pc_q  <= pc_d;
      mar_q <= mar_d;
      mdr_q <= mdr_d;
      ir_q  <= ir_d;
      acc_q <= acc_d;
    end
  end

  assign pc    = pc_q;
  assign mar   = mar_q;
  assign mdr   = mdr_q;
  assign ir_op = ir_q[DATA_W-1:OP_LSB];
  assign acc   = acc_q;

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_q != $past(pc_q)) |-> (pc_q == $past(pc_q) + ADDR_W'(1)));

  // R8
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(pc_q) && $stable(acc_q) && $stable(ir_q) && $stable(mar_q)));

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OP_W   = 4,
  parameter int ADDR_W = 12,
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              host_we,
  input  logic [MEM_AW-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] acc,
  output logic              halted
);
  logic rst_meta, rst_core;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_core <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_core <= rst_meta;
    end
  end

  xfer_t             xfer;
  logic              core_we;
  logic [ADDR_W-1:0] mar;
  logic [DATA_W-1:0] mdr;
  logic [OP_W-1:0]   ir_op;
  logic [DATA_W-1:0] mem_rdata;
  logic [MEM_AW-1:0] port_addr;
  logic [DATA_W-1:0] port_wdata;
  logic              port_we;

  acc_core_ctrl #(.OP_W(OP_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_core),
    .en     (run),
    .ir_op  (ir_op),
    .xfer   (xfer),
    .mem_we (core_we),
    .halted (halted)
  );

  acc_core_dp #(.DATA_W(DATA_W), .OP_W(OP_W), .ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_core),
    .en        (run),
    .xfer      (xfer),
    .mem_rdata (mem_rdata),
    .pc        (pc),
    .mar       (mar),
    .mdr       (mdr),
    .ir_op     (ir_op),
    .acc       (acc)
  );

  generate
    if (ADDR_W > MEM_AW) begin : g_fold
      logic unused_mar_hi;
      assign unused_mar_hi = ^mar[ADDR_W-1:MEM_AW];
      assign port_addr = run ? mar[MEM_AW-1:0] : host_addr;
    end else begin : g_full
      assign port_addr = run ? MEM_AW'(mar) : host_addr;
    end
  endgenerate

  assign port_we    = run ? core_we : host_we;
  assign port_wdata = run ? mdr : host_wdata;

  acc_core_mem #(.DATA_W(DATA_W), .AW(MEM_AW)) u_mem (
    .clk   (clk),
    .we    (port_we),
    .addr  (port_addr),
    .wdata (port_wdata),
    .rdata (mem_rdata)
  );

  assign host_rdata = mem_rdata;

  // R6
  halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_core)
    halted |=> (halted && $stable(pc) && $stable(acc)));

  // R5
  store_data_chk: assert property (@(posedge clk) disable iff (!rst_core)
    (run && core_we) |-> (mdr == acc));

endmodule

// File: tb/acc_core_bench.sv
module acc_core_bench;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 12;
  localparam int MEM_AW = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              run;
  logic              host_we;
  logic [MEM_AW-1:0] host_addr;
  logic [DATA_W-1:0] host_wdata;
  logic [DATA_W-1:0] host_rdata;
  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] acc;
  logic              halted;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  acc_core #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_acc_core (
    .clk(clk), .rst_n(rst_n), .run(run), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .pc(pc), .acc(acc), .halted(halted)
  );

  // operand A, operand B, expected (A+B) mod 2^16
  localparam logic [47:0] VEC_TAB [8] = '{
    48'h0000_0000_0000,
    48'h0001_0002_0003,
    48'hFFFF_0001_0000,
    48'h8000_8000_0000,
    48'h1234_4321_5555,
    48'hFFFF_FFFF_FFFE,
    48'hAAAA_5555_FFFF,
    48'h7FFF_0001_8000
  };

  function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] a);
    return {op, a};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; run = 1'b0; host_we = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(3);
  endtask

  task automatic poke(input logic [7:0] a, input logic [15:0] d);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    tick(1);
    host_we = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [15:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic wait_halt(input string tag);
    int k = 0;
    while (!halted && k < 500) begin
      tick(1);
      k++;
    end
    if (!halted) chk({tag, " halt timeout"}, 0, 1);
  endtask

  initial begin
    logic [15:0] rd;
    logic [11:0] pc_hold;
    logic [15:0] acc_hold;
    rst_n = 1'b0; run = 1'b0; host_we = 1'b0;
    host_addr = '0; host_wdata = '0;

    // vector table: LOAD 040, ADD 041, STORE 042, HALT (R3 R4 R5 R6)
    foreach (VEC_TAB[i]) begin
      do_reset();
      poke(8'h00, ins(4'h0, 12'h040));
      poke(8'h01, ins(4'h1, 12'h041));
      poke(8'h02, ins(4'h2, 12'h042));
      poke(8'h03, ins(4'hF, 12'h000));
      poke(8'h40, VEC_TAB[i][47:32]);
      poke(8'h41, VEC_TAB[i][31:16]);
      poke(8'h42, 16'hDEAD);
      run = 1'b1;
      wait_halt("R6 vec");
      chk("R4 acc sum", 32'(acc), 32'(VEC_TAB[i][15:0]));
      chk("R6 pc after halt", 32'(pc), 32'h4);
      run = 1'b0;
      peek(8'h42, rd);
      chk("R5 stored word", 32'(rd), 32'(VEC_TAB[i][15:0]));
    end

    // R1 reset state
    do_reset();
    chk("R1 pc", 32'(pc), 0);
    chk("R1 acc", 32'(acc), 0);
    chk("R1 halted", 32'(halted), 0);

    // R2 R3 cycle timing: LOAD 040 then HALT
    poke(8'h00, ins(4'h0, 12'h040));
    poke(8'h01, ins(4'hF, 12'h000));
    poke(8'h40, 16'h00C3);
    run = 1'b1;
    tick(1);
    chk("R2 pc after first fetch cycle", 32'(pc), 1);
    tick(4);
    chk("R3 acc before exec edge", 32'(acc), 0);
    tick(1);
    chk("R3 acc at sixth edge", 32'(acc), 32'h00C3);
    tick(1);
    chk("R2 pc at next fetch", 32'(pc), 2);
    tick(2);
    chk("R6 not halted before decode", 32'(halted), 0);
    tick(1);
    chk("R6 halted at fourth edge", 32'(halted), 1);

    // R6 hold, R8 host write ignored while running
    pc_hold = pc; acc_hold = acc;
    poke(8'h40, 16'h1111);
    tick(20);
    chk("R6 halted held", 32'(halted), 1);
    chk("R6 pc held", 32'(pc), 32'(pc_hold));
    chk("R6 acc held", 32'(acc), 32'(acc_hold));
    run = 1'b0;
    peek(8'h40, rd);
    chk("R8 host write ignored while run", 32'(rd), 32'h00C3);

    // R8 pause mid-instruction, host write during pause
    do_reset();
    poke(8'h00, ins(4'h0, 12'h040));
    poke(8'h01, ins(4'hF, 12'h000));
    poke(8'h40, 16'h0011);
    run = 1'b1;
    tick(3);
    run = 1'b0;
    tick(8);
    chk("R8 pc frozen", 32'(pc), 1);
    chk("R8 acc frozen", 32'(acc), 0);
    poke(8'h40, 16'h0077);
    run = 1'b1;
    wait_halt("R8");
    chk("R8 host write seen by core", 32'(acc), 32'h0077);

    // R7 undefined opcodes, R9 address folding
    do_reset();
    poke(8'h00, ins(4'h0, 12'h940));
    poke(8'h01, ins(4'h3, 12'h040));
    poke(8'h02, ins(4'hE, 12'h023));
    poke(8'h03, ins(4'h2, 12'hA55));
    poke(8'h04, ins(4'h1, 12'h040));
    poke(8'h05, ins(4'hF, 12'h000));
    poke(8'h40, 16'h0005);
    poke(8'h23, 16'hBEEF);
    poke(8'h55, 16'h0000);
    run = 1'b1;
    wait_halt("R7");
    chk("R7 acc after no-ops", 32'(acc), 32'h000A);
    chk("R7 pc after six words", 32'(pc), 6);
    run = 1'b0;
    peek(8'h40, rd);
    chk("R7 operand word untouched", 32'(rd), 32'h0005);
    peek(8'h23, rd);
    chk("R7 no-op target untouched", 32'(rd), 32'hBEEF);
    peek(8'h55, rd);
    chk("R9 folded store address", 32'(rd), 32'h0005);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule